// File: doc/BRIEF.md
# Hierarchical Tag-Matching Spike Router Node

This block is one node of a row of spike routers. Rows are arranged in levels. Each spike event carries a tag that names a destination pattern. A node has an attachment port and two row ports, one to each neighbour. In an array node the attachment port goes to a neuron array. In an edge node the attachment port goes to the next level up.

An event from the attachment port is spread into the row in both directions. The one exception is an array node given an event marked as local: that event returns straight to the array and never enters the row. An event that arrives from a neighbour keeps moving the way it was travelling. The node also looks up its tag in the node's own membership table, and on a hit it hands a copy to the attachment port. In an array node a hit means the event is delivered to the array. In an edge node a hit means the event is escalated to the next level. A node marked as a row end does not forward past that end.

One event at a time is held in a fork register. It stays there until every output it needs has accepted it. The three inputs are served in round-robin order.

Top module: `tagrt_node`

## Requirements
- R1: While reset is asserted and after it is released, no output valid is high, and every entry of the membership table reads as a miss.
- R2: In an array node (EDGE_NODE=0), an attachment event with `att_in_local`=1 is presented only on the attachment output and never on either row output.
- R3: An attachment event that is not looped back is presented on the left output unless LEFT_END=1, and on the right output unless RIGHT_END=1. It is never returned to the attachment output.
- R4: An event taken from the left input is presented on the right output (unless RIGHT_END=1), and on the attachment output exactly when its tag's table bit is 1. It never goes back out of the left output.
- R5: An event taken from the right input is presented on the left output (unless LEFT_END=1), and on the attachment output exactly when its tag's table bit is 1. It never goes back out of the right output.
- R6: A node with RIGHT_END=1 never raises the right output valid, and one with LEFT_END=1 never raises the left output valid. An event that needs no output at all is consumed and dropped.
- R7: In an edge node (EDGE_NODE=1), `att_in_local` has no effect. An event from the upper level is always spread into the row, and a row event goes up only on a table hit.
- R8: A write with `cfg_we`=1 sets table bit `cfg_tag` to `cfg_set`. The new value governs every event accepted after that clock edge.
- R9: A presented copy keeps its valid and tag steady until its output accepts it. No new input is accepted while any copy of the held event is still unaccepted.
- R10: At most one input is accepted per cycle. A waiting input is accepted before three other inputs are accepted (round robin).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_tag | input | TAG_W | Table entry to write |
| cfg_set | input | 1 | Value written: 1 = member, 0 = not |
| att_in_valid | input | 1 | Attachment input valid (array or upper level) |
| att_in_ready | output | 1 | Attachment input accepted |
| att_in_tag | input | TAG_W | Attachment input tag |
| att_in_local | input | 1 | Event's destination is the originating array |
| att_out_valid | output | 1 | Attachment output valid (delivery or escalation) |
| att_out_ready | input | 1 | Attachment output taken |
| att_out_tag | output | TAG_W | Attachment output tag |
| lft_in_valid | input | 1 | Valid from the left neighbour |
| lft_in_ready | output | 1 | Left input accepted |
| lft_in_tag | input | TAG_W | Left input tag |
| lft_out_valid | output | 1 | Valid to the left neighbour |
| lft_out_ready | input | 1 | Left output taken |
| lft_out_tag | output | TAG_W | Left output tag |
| rgt_in_valid | input | 1 | Valid from the right neighbour |
| rgt_in_ready | output | 1 | Right input accepted |
| rgt_in_tag | input | TAG_W | Right input tag |
| rgt_out_valid | output | 1 | Valid to the right neighbour |
| rgt_out_ready | input | 1 | Right output taken |
| rgt_out_tag | output | TAG_W | Right output tag |

## Verification
A middle array node and a right-end edge node are each driven from every input. The same tag is sent before a table write, after it, and after it is cleared, which separates a table hit from a miss and shows writes taking effect. Local and non-local attachment events are sent to both node kinds, which separates loopback from spreading into the row and shows that the local mark is ignored at the edge. A burst under random output back-pressure, followed by all three inputs competing at once, tests holding until every copy is taken and round-robin service.

// File: rtl/tagrt_pkg.sv
package tagrt_pkg;
  localparam int NSRC = 3;
  localparam int NOUT = 3;
  // output bit positions: 0 attachment, 1 left, 2 right
  localparam int O_ATT = 0;
  localparam int O_LFT = 1;
  localparam int O_RGT = 2;

  typedef enum logic [1:0] {SRC_ATT = 2'd0, SRC_LFT = 2'd1, SRC_RGT = 2'd2} src_e;

  // Which outputs a granted event must reach.
  function automatic logic [NOUT-1:0] route_mask(src_e src, logic loc, logic hit,
                                                 logic edge_node, logic lend, logic rend);
    logic [NOUT-1:0] m;
    m = '0;
    unique case (src)
      SRC_ATT: begin
        if (loc && !edge_node) m[O_ATT] = 1'b1;
        else begin
          m[O_LFT] = !lend;
          m[O_RGT] = !rend;
        end
      end
      SRC_LFT: begin
        m[O_RGT] = !rend;
        m[O_ATT] = hit;
      end
      default: begin
        m[O_LFT] = !lend;
        m[O_ATT] = hit;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tagrt_table.sv
module tagrt_table #(
  parameter int TAG_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             wr_val,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit
);
  localparam int DEPTH = 1 << TAG_W;
  logic [DEPTH-1:0] member;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) member <= '0;
    else if (wr_en) member[wr_tag] <= wr_val;
  end

  assign rd_hit = member[rd_tag];
endmodule

// File: rtl/tagrt_rr_arb.sv
module tagrt_rr_arb #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         en,
  output logic [N-1:0] grant
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  logic [PW-1:0] last_q;
  logic [PW-1:0] win;

  always_comb begin
    grant = '0;
    win   = last_q;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(last_q) + k) % N;
      if (en && req[idx] && grant == '0) begin
        grant[idx] = 1'b1;
        win        = idx[PW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= PW'(N - 1);
    else if (|grant) last_q <= win;
  end
endmodule

// File: rtl/tagrt_fork.sv
module tagrt_fork #(
  parameter int TAG_W = 6,
  parameter int NOUT  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [NOUT-1:0] load_mask,
  input  logic [TAG_W-1:0] load_tag,
  input  logic [NOUT-1:0] out_ready,
  output logic [NOUT-1:0] out_valid,
  output logic [TAG_W-1:0] out_tag,
  output logic            room
);
  logic [NOUT-1:0] pend_q;
  logic [TAG_W-1:0] tag_q;
  logic [NOUT-1:0] taken;
  logic [NOUT-1:0] still;

  assign taken = pend_q & out_ready;
  assign still = pend_q & ~taken;
  assign room  = (still == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      tag_q  <= '0;
    end else if (room) begin
      pend_q <= load ? load_mask : '0;
      if (load) tag_q <= load_tag;
    end else begin
      pend_q <= still;
    end
  end

  assign out_valid = pend_q;
  assign out_tag   = tag_q;
endmodule

// File: rtl/tagrt_node.sv
module tagrt_node
  import tagrt_pkg::*;
#(
  parameter int TAG_W     = 6,
  parameter bit EDGE_NODE = 1'b0,
  parameter bit LEFT_END  = 1'b0,
  parameter bit RIGHT_END = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [TAG_W-1:0] cfg_tag,
  input  logic             cfg_set,
  input  logic             att_in_valid,
  output logic             att_in_ready,
  input  logic [TAG_W-1:0] att_in_tag,
  input  logic             att_in_local,
  output logic             att_out_valid,
  input  logic             att_out_ready,
  output logic [TAG_W-1:0] att_out_tag,
  input  logic             lft_in_valid,
  output logic             lft_in_ready,
  input  logic [TAG_W-1:0] lft_in_tag,
  output logic             lft_out_valid,
  input  logic             lft_out_ready,
  output logic [TAG_W-1:0] lft_out_tag,
  input  logic             rgt_in_valid,
  output logic             rgt_in_ready,
  input  logic [TAG_W-1:0] rgt_in_tag,
  output logic             rgt_out_valid,
  input  logic             rgt_out_ready,
  output logic [TAG_W-1:0] rgt_out_tag
);
  // named internal events, observed by the bound checker
  logic [NSRC-1:0] req;
  logic [NSRC-1:0] grant;
  logic            room;
  logic            ev_accept;
  src_e            ev_src;
  logic [TAG_W-1:0] ev_tag;
  logic            ev_hit;
  logic [NOUT-1:0] ev_mask;
  logic [NOUT-1:0] fk_valid;
  logic [NOUT-1:0] fk_ready;
  logic [TAG_W-1:0] fk_tag;

  assign req = {rgt_in_valid, lft_in_valid, att_in_valid};

  tagrt_rr_arb #(.N(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .en(room), .grant(grant)
  );

  assign att_in_ready = grant[SRC_ATT];
  assign lft_in_ready = grant[SRC_LFT];
  assign rgt_in_ready = grant[SRC_RGT];
  assign ev_accept    = |grant;

  always_comb begin
    ev_src = SRC_ATT;
    ev_tag = att_in_tag;
    if (grant[SRC_LFT]) begin
      ev_src = SRC_LFT;
      ev_tag = lft_in_tag;
    end else if (grant[SRC_RGT]) begin
      ev_src = SRC_RGT;
      ev_tag = rgt_in_tag;
    end
  end

  tagrt_table #(.TAG_W(TAG_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_tag(cfg_tag), .wr_val(cfg_set),
    .rd_tag(ev_tag), .rd_hit(ev_hit)
  );

  assign ev_mask = route_mask(ev_src, att_in_local, ev_hit, EDGE_NODE, LEFT_END, RIGHT_END);

  assign fk_ready = {rgt_out_ready, lft_out_ready, att_out_ready};

  tagrt_fork #(.TAG_W(TAG_W), .NOUT(NOUT)) u_fork (
    .clk(clk), .rst_n(rst_n), .load(ev_accept), .load_mask(ev_mask), .load_tag(ev_tag),
    .out_ready(fk_ready), .out_valid(fk_valid), .out_tag(fk_tag), .room(room)
  );

  assign att_out_valid = fk_valid[O_ATT];
  assign lft_out_valid = fk_valid[O_LFT];
  assign rgt_out_valid = fk_valid[O_RGT];
  assign att_out_tag   = fk_tag;
  assign lft_out_tag   = fk_tag;
  assign rgt_out_tag   = fk_tag;
endmodule

// File: rtl/tagrt_node_chk.sv
module tagrt_node_chk #(
  parameter int TAG_W     = 6,
  parameter bit EDGE_NODE = 1'b0,
  parameter bit LEFT_END  = 1'b0,
  parameter bit RIGHT_END = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       req,
  input logic [2:0]       grant,
  input logic [2:0]       out_valid,
  input logic [2:0]       out_ready,
  input logic [TAG_W-1:0] out_tag,
  input logic             att_local
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> out_valid == 3'b000);

  if (!EDGE_NODE) begin : g_loop
    assert_loopback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      grant[0] && att_local |=> out_valid == 3'b001);
  end

  assert_no_attach_echo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    grant[0] && (!att_local || EDGE_NODE) |=> !out_valid[0]);
  assert_no_left_echo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    grant[1] |=> !out_valid[1]);
  assert_no_right_echo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant[2] |=> !out_valid[2]);

  if (LEFT_END) begin : g_lend
    assert_left_end_R6: assert property (@(posedge clk) disable iff (!rst_n) !out_valid[1]);
  end
  if (RIGHT_END) begin : g_rend
    assert_right_end_R6: assert property (@(posedge clk) disable iff (!rst_n) !out_valid[2]);
  end

  for (genvar i = 0; i < 3; i++) begin : g_out
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[i] && !out_ready[i] |=> out_valid[i] && $stable(out_tag));
    assert_no_take_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[i] && !out_ready[i] |-> grant == 3'b000);
  end

  assert_one_grant_R10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  for (genvar i = 0; i < 3; i++) begin : g_wait
    logic [2:0] waits;
    always @(posedge clk or negedge rst_n) begin
      if (!rst_n) waits <= '0;
      else if (grant[i] || !req[i]) waits <= '0;
      else if (|grant) waits <= waits + 3'd1;
    end
    assert_fair_R10: assert property (@(posedge clk) disable iff (!rst_n) waits < 3'd3);
  end
endmodule

bind tagrt_node tagrt_node_chk #(
  .TAG_W(TAG_W), .EDGE_NODE(EDGE_NODE), .LEFT_END(LEFT_END), .RIGHT_END(RIGHT_END)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .out_valid(fk_valid),
  .out_ready(fk_ready), .out_tag(fk_tag), .att_local(att_in_local)
);

// File: tb/tb_tagrt_node.sv
`timescale 1ns/1ps
module tb_tagrt_node;
  localparam int TW = 6;
  typedef struct packed { logic [TW-1:0] tag; logic [3:0] rq; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  // node 0: middle array node; node 1: right-end edge node
  logic          cfg_we [2];
  logic [TW-1:0] cfg_tag [2];
  logic          cfg_set [2];
  logic          in_v [2][3];
  logic          in_r [2][3];
  logic [TW-1:0] in_t [2][3];
  logic          in_loc [2];
  logic          out_v [2][3];
  logic          out_r [2][3];
  logic [TW-1:0] out_t [2][3];

  logic          tbl [2][64];
  exp_t          expq [2][3][$];
  logic          was_stalled [2][3];
  logic [TW-1:0] stalled_tag [2][3];
  int checks = 0, errors = 0;
  logic stall = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic done = 1'b0;

  tagrt_node #(.TAG_W(TW), .EDGE_NODE(1'b0), .LEFT_END(1'b0), .RIGHT_END(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[0]), .cfg_tag(cfg_tag[0]), .cfg_set(cfg_set[0]),
    .att_in_valid(in_v[0][0]), .att_in_ready(in_r[0][0]), .att_in_tag(in_t[0][0]),
    .att_in_local(in_loc[0]),
    .att_out_valid(out_v[0][0]), .att_out_ready(out_r[0][0]), .att_out_tag(out_t[0][0]),
    .lft_in_valid(in_v[0][1]), .lft_in_ready(in_r[0][1]), .lft_in_tag(in_t[0][1]),
    .lft_out_valid(out_v[0][1]), .lft_out_ready(out_r[0][1]), .lft_out_tag(out_t[0][1]),
    .rgt_in_valid(in_v[0][2]), .rgt_in_ready(in_r[0][2]), .rgt_in_tag(in_t[0][2]),
    .rgt_out_valid(out_v[0][2]), .rgt_out_ready(out_r[0][2]), .rgt_out_tag(out_t[0][2])
  );

  tagrt_node #(.TAG_W(TW), .EDGE_NODE(1'b1), .LEFT_END(1'b0), .RIGHT_END(1'b1)) dut_edge (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we[1]), .cfg_tag(cfg_tag[1]), .cfg_set(cfg_set[1]),
    .att_in_valid(in_v[1][0]), .att_in_ready(in_r[1][0]), .att_in_tag(in_t[1][0]),
    .att_in_local(in_loc[1]),
    .att_out_valid(out_v[1][0]), .att_out_ready(out_r[1][0]), .att_out_tag(out_t[1][0]),
    .lft_in_valid(in_v[1][1]), .lft_in_ready(in_r[1][1]), .lft_in_tag(in_t[1][1]),
    .lft_out_valid(out_v[1][1]), .lft_out_ready(out_r[1][1]), .lft_out_tag(out_t[1][1]),
    .rgt_in_valid(in_v[1][2]), .rgt_in_ready(in_r[1][2]), .rgt_in_tag(in_t[1][2]),
    .rgt_out_valid(out_v[1][2]), .rgt_out_ready(out_r[1][2]), .rgt_out_tag(out_t[1][2])
  );

  // Expected copies, restated from the requirements: index 0 attach, 1 left, 2 right.
  function automatic logic [2:0] expect_outs(int n, int s, logic loc, logic [TW-1:0] tag);
    logic is_edge, right_end;
    logic [2:0] r;
    is_edge   = (n == 1);
    right_end = (n == 1);
    r = 3'b000;
    if (s == 0) begin
      if (!is_edge && loc) r[0] = 1'b1;                     // R2
      else begin r[1] = 1'b1; r[2] = !right_end; end        // R3, R7
    end else if (s == 1) begin
      r[2] = !right_end; r[0] = tbl[n][tag];                // R4, R6
    end else begin
      r[1] = 1'b1; r[0] = tbl[n][tag];                      // R5
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic send(input int n, input int s, input logic [TW-1:0] tag, input logic loc,
                      input logic [3:0] rq);
    logic [2:0] m;
    m = expect_outs(n, s, loc, tag);
    for (int o = 0; o < 3; o++) if (m[o]) expq[n][o].push_back('{tag: tag, rq: rq});
    @(negedge clk);
    in_t[n][s] = tag;
    if (s == 0) in_loc[n] = loc;
    in_v[n][s] = 1'b1;
    #1;
    while (!in_r[n][s]) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_v[n][s] = 1'b0;
  endtask

  task automatic cfg(input int n, input logic [TW-1:0] tag, input logic val);
    @(negedge clk);
    cfg_we[n] = 1'b1; cfg_tag[n] = tag; cfg_set[n] = val;
    @(negedge clk);
    cfg_we[n] = 1'b0;
    tbl[n][tag] = val;
  endtask

  task automatic drain(input string rq);
    int left_cnt;
    for (int c = 0; c < 400; c++) begin
      left_cnt = 0;
      for (int n = 0; n < 2; n++) for (int o = 0; o < 3; o++) left_cnt += expq[n][o].size();
      if (left_cnt == 0) break;
      @(negedge clk);
    end
    repeat (6) @(negedge clk);
    for (int n = 0; n < 2; n++) for (int o = 0; o < 3; o++)
      check(expq[n][o].size() == 0, rq, $sformatf("node%0d out%0d copies missing", n, o),
            expq[n][o].size(), 0);
  endtask

  // back-pressure
  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int n = 0; n < 2; n++) for (int o = 0; o < 3; o++)
      out_r[n][o] = stall ? lfsr[n*3+o] : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int n = 0; n < 2; n++) for (int o = 0; o < 3; o++) begin
        if (was_stalled[n][o])   // R9: held copy still offered, unchanged
          check(out_v[n][o] && out_t[n][o] == stalled_tag[n][o], "R9",
                $sformatf("node%0d out%0d held copy", n, o), int'(out_t[n][o]),
                int'(stalled_tag[n][o]));
        was_stalled[n][o] = out_v[n][o] && !out_r[n][o];
        stalled_tag[n][o] = out_t[n][o];
        if (out_v[n][o] && out_r[n][o]) begin
          if (expq[n][o].size() == 0)
            check(1'b0, "R2/R3/R4/R5/R6/R7", $sformatf("node%0d out%0d unexpected copy", n, o),
                  int'(out_t[n][o]), -1);
          else begin
            exp_t e;
            e = expq[n][o].pop_front();
            check(out_t[n][o] == e.tag, $sformatf("R%0d", e.rq),
                  $sformatf("node%0d out%0d tag", n, o), int'(out_t[n][o]), int'(e.tag));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int n = 0; n < 2; n++) begin
      cfg_we[n] = 1'b0; cfg_tag[n] = '0; cfg_set[n] = 1'b0; in_loc[n] = 1'b0;
      for (int t = 0; t < 64; t++) tbl[n][t] = 1'b0;
      for (int s = 0; s < 3; s++) begin
        in_v[n][s] = 1'b0; in_t[n][s] = '0; out_r[n][s] = 1'b1; was_stalled[n][s] = 1'b0;
        stalled_tag[n][s] = '0;
      end
    end
    repeat (4) @(negedge clk);
    for (int n = 0; n < 2; n++) for (int o = 0; o < 3; o++)
      check(out_v[n][o] == 1'b0, "R1", $sformatf("node%0d out%0d valid in reset", n, o),
            int'(out_v[n][o]), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    for (int n = 0; n < 2; n++) for (int o = 0; o < 3; o++)
      check(out_v[n][o] == 1'b0, "R1", $sformatf("node%0d out%0d valid after reset", n, o),
            int'(out_v[n][o]), 0);

    // R1 R4: cleared table, left event goes only to the right
    send(0, 1, 6'd5, 1'b0, 4'd4);
    drain("R1");
    // R8: set then use, from both sides
    cfg(0, 6'd5, 1'b1);
    send(0, 1, 6'd5, 1'b0, 4'd8);
    send(0, 2, 6'd5, 1'b0, 4'd5);
    drain("R8");
    cfg(0, 6'd5, 1'b0);
    send(0, 2, 6'd5, 1'b0, 4'd8);
    send(0, 1, 6'd33, 1'b0, 4'd4);
    drain("R8");
    // R2 loopback, R3 spreading
    send(0, 0, 6'd9, 1'b1, 4'd2);
    send(0, 0, 6'd9, 1'b0, 4'd3);
    send(0, 0, 6'd63, 1'b1, 4'd2);
    drain("R3");
    // R6 R7 on the right-end edge node
    cfg(1, 6'd12, 1'b1);
    send(1, 1, 6'd12, 1'b0, 4'd7);
    send(1, 1, 6'd3, 1'b0, 4'd6);
    send(1, 0, 6'd7, 1'b1, 4'd7);
    send(1, 0, 6'd12, 1'b0, 4'd7);
    drain("R7");
    // R9: burst under random back-pressure
    cfg(0, 6'd2, 1'b1);
    cfg(0, 6'd7, 1'b1);
    stall = 1'b1;
    for (int k = 0; k < 16; k++) send(0, k % 3, 6'(k), k[2], 4'd9);
    drain("R9");
    // R10: all three inputs compete, outputs disjoint
    for (int k = 0; k < 6; k++) begin
      fork
        send(0, 0, 6'(40 + k), 1'b1, 4'd10);
        send(0, 1, 6'(20 + k), 1'b0, 4'd10);
        send(0, 2, 6'(50 + k), 1'b0, 4'd10);
      join
    end
    drain("R10");
    stall = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule